// File: doc/BRIEF.md
# Coin-Credit Vending Controller

This block is the control core of a two-drink vending machine. Coins worth 50 or 100 units arrive as single-clock pulses. The block keeps the running credit in 50-unit steps, from 0 to 6 steps, so the ceiling is 300 units. A coin that would take the credit past the ceiling is turned away. Two select buttons buy a 100-unit drink (drink A) or a 200-unit drink (drink B). A purchase only happens when the credit covers the price, and whatever credit is left after the purchase is kept. All inputs are assumed clean and synchronous to the clock.

A return button starts a refund of the whole balance. The refund is paid out as a stream of 50-unit tokens over a valid/ready pair. `refund_valid_o` stays high while credit remains. Each cycle in which `refund_ready_i` is also high hands over one token and lowers the credit by one step. Holding `refund_ready_i` low stalls the stream, and valid and credit both hold. While a refund is in progress, coin, select and return inputs are ignored.

Every output comes from a register or from a decode of the credit register. Dispense strobes and the reject pulse each last exactly one clock. The credit is also shown as a thermometer of LED lines.

Top module: `vend_ctrl`

## Requirements
- R1: After a synchronous active-high reset, credit is 0, all LED lines are off, and `disp_a_o`, `disp_b_o`, `coin_rej_o` and `refund_valid_o` are low.
- R2: When idle, with no select or return in the same cycle, a 50-unit coin adds 1 step and a 100-unit coin adds 2 steps, and both together add 3. The new value shows on `credit_o` one clock later. LED bit i is lit exactly when credit is greater than i steps (bit 0 means at least 50 units).
- R3: A coin (or coin pair) that would take the credit above 6 steps is not added. `coin_rej_o` pulses for one clock and the credit is unchanged.
- R4: `sel_a_i` with credit of at least 2 steps raises `disp_a_o` for exactly one clock and subtracts 2 steps. With less credit it has no effect.
- R5: `sel_b_i` with credit of at least 4 steps raises `disp_b_o` for exactly one clock and subtracts 4 steps, keeping any remainder.
- R6: A select when the credit is below that drink's price gives no strobe and leaves the credit unchanged.
- R7: If both selects arrive in one cycle, only drink A is considered and `sel_b_i` is ignored.
- R8: A coin arriving in the same cycle as a select or a return is not credited. It is rejected with a one-clock `coin_rej_o` pulse.
- R9: Return with non-zero credit raises `refund_valid_o` on the next clock. With `refund_ready_i` held high, exactly one token per clock is handed over, equal in number to the stored steps. Afterwards the credit is 0 and `refund_valid_o` is low.
- R10: While `refund_valid_o` is high and `refund_ready_i` is low, `refund_valid_o` stays high and the credit stays unchanged.
- R11: During a refund, coin, select and return pulses are ignored: no credit change beyond token hand-over, no strobe, and no reject.
- R12: Return has priority over both selects in the same cycle. Return with zero credit does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_50_i | input | 1 | One-clock pulse: 50-unit coin inserted |
| coin_100_i | input | 1 | One-clock pulse: 100-unit coin inserted |
| sel_a_i | input | 1 | One-clock pulse: request drink A (100 units) |
| sel_b_i | input | 1 | One-clock pulse: request drink B (200 units) |
| ret_i | input | 1 | One-clock pulse: return all credit |
| refund_ready_i | input | 1 | Refund token sink ready |
| disp_a_o | output | 1 | One-clock dispense strobe, drink A |
| disp_b_o | output | 1 | One-clock dispense strobe, drink B |
| coin_rej_o | output | 1 | One-clock pulse: coin turned away |
| refund_valid_o | output | 1 | A 50-unit refund token is offered |
| credit_o | output | 3 | Stored credit in 50-unit steps |
| credit_led_o | output | 6 | Thermometer credit display |

## Verification
Several functions can land in the same cycle: a purchase with a coin, a return with a select and a coin, two selects, and a coin or return while tokens are being stalled. Each case is provoked by raising the competing pulses on one falling edge. The result is judged on the next falling edge. The check confirms that the winning action alone changed the credit or raised its strobe, and that a losing coin shows up as a reject pulse.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_ADD,
    ACT_BUY_A,
    ACT_BUY_B,
    ACT_REFUND
  } vend_act_e;

  typedef enum logic {
    MODE_IDLE,
    MODE_REFUND
  } vend_mode_e;

endpackage

// File: rtl/vend_arbiter.sv
module vend_arbiter
  import vend_pkg::*;
#(
  parameter int CREDIT_MAX = 6,
  parameter int CW         = 3,
  parameter int COIN_LO    = 1,
  parameter int COIN_HI    = 2,
  parameter int PRICE_A    = 2,
  parameter int PRICE_B    = 4
) (
  input  logic [CW-1:0] credit,
  input  logic          refunding,
  input  logic          coin_lo,
  input  logic          coin_hi,
  input  logic          sel_a,
  input  logic          sel_b,
  input  logic          ret,
  output vend_act_e     act,
  output logic [CW-1:0] add_steps,
  output logic          reject
);
  localparam int SW = CW + 2;

  logic [SW-1:0] sum;
  logic          any_coin;
  logic          command;

  always_comb begin
    add_steps = (coin_lo ? CW'(COIN_LO) : '0) + (coin_hi ? CW'(COIN_HI) : '0);
    sum       = SW'(credit) + SW'(add_steps);
    any_coin  = coin_lo | coin_hi;
    command   = ret | sel_a | sel_b;
    act       = ACT_NONE;
    reject    = 1'b0;
    if (!refunding) begin
      if (ret) begin
        if (credit != '0) act = ACT_REFUND;
      end else if (sel_a) begin
        if (credit >= CW'(PRICE_A)) act = ACT_BUY_A;
      end else if (sel_b) begin
        if (credit >= CW'(PRICE_B)) act = ACT_BUY_B;
      end else if (any_coin) begin
        if (sum > SW'(CREDIT_MAX)) reject = 1'b1;
        else act = ACT_ADD;
      end
      if (command && any_coin) reject = 1'b1;
    end
  end

  // R8: a coin is never both credited and rejected
  always_comb begin
    if (act == ACT_ADD) assert (!reject);
  end

endmodule

// File: rtl/vend_credit_core.sv
module vend_credit_core
  import vend_pkg::*;
#(
  parameter int CREDIT_MAX = 6,
  parameter int CW         = 3,
  parameter int PRICE_A    = 2,
  parameter int PRICE_B    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  vend_act_e     act,
  input  logic [CW-1:0] add_steps,
  input  logic          reject,
  input  logic          refund_ready,
  output logic [CW-1:0] credit,
  output logic          refunding,
  output logic          disp_a,
  output logic          disp_b,
  output logic          coin_rej
);
  vend_mode_e    mode_q;
  logic [CW-1:0] credit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_IDLE;
      credit_q <= '0;
      disp_a   <= 1'b0;
      disp_b   <= 1'b0;
      coin_rej <= 1'b0;
    end else begin
      disp_a   <= 1'b0;
      disp_b   <= 1'b0;
      coin_rej <= reject;
      if (mode_q == MODE_IDLE) begin
        unique case (act)
          ACT_ADD:    credit_q <= credit_q + add_steps;
          ACT_BUY_A: begin
            credit_q <= credit_q - CW'(PRICE_A);
            disp_a   <= 1'b1;
          end
          ACT_BUY_B: begin
            credit_q <= credit_q - CW'(PRICE_B);
            disp_b   <= 1'b1;
          end
          ACT_REFUND: mode_q <= MODE_REFUND;
          default: ;
        endcase
      end else if (refund_ready) begin
        credit_q <= credit_q - 1'b1;
        if (credit_q == CW'(1)) mode_q <= MODE_IDLE;
      end
    end
  end

  assign credit    = credit_q;
  assign refunding = (mode_q == MODE_REFUND);

  p_ceiling_r3: assert property (@(posedge clk) disable iff (rst)
    credit_q <= CW'(CREDIT_MAX));

  p_one_drink_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({disp_a, disp_b}));

  p_price_a_r4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_BUY_A && mode_q == MODE_IDLE) |=> (disp_a && credit_q == $past(credit_q) - CW'(PRICE_A)));

  p_price_b_r5: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_BUY_B && mode_q == MODE_IDLE) |=> (disp_b && credit_q == $past(credit_q) - CW'(PRICE_B)));

  p_token_step_r9: assert property (@(posedge clk) disable iff (rst)
    (refunding && refund_ready) |=> (credit_q == $past(credit_q) - CW'(1)));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (refunding && !refund_ready) |=> (refunding && $stable(credit_q)));

  p_valid_has_credit_r9: assert property (@(posedge clk) disable iff (rst)
    refunding |-> (credit_q != '0));

  p_quiet_refund_r11: assert property (@(posedge clk) disable iff (rst)
    refunding |=> (!disp_a && !disp_b && !coin_rej));

endmodule

// File: rtl/vend_led.sv
module vend_led #(
  parameter int CREDIT_MAX = 6,
  parameter int CW         = 3
) (
  input  logic [CW-1:0]         credit,
  output logic [CREDIT_MAX-1:0] led
);
  for (genvar i = 0; i < CREDIT_MAX; i++) begin : g_bar
    assign led[i] = (credit > CW'(i));
  end

  // R2: the display is always a contiguous bar from bit 0
  always_comb begin
    assert ((led & (led + 1'b1)) == '0);
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int CREDIT_MAX = 6,
  parameter int COIN_LO    = 1,
  parameter int COIN_HI    = 2,
  parameter int PRICE_A    = 2,
  parameter int PRICE_B    = 4,
  localparam int CW        = $clog2(CREDIT_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  coin_50_i,
  input  logic                  coin_100_i,
  input  logic                  sel_a_i,
  input  logic                  sel_b_i,
  input  logic                  ret_i,
  input  logic                  refund_ready_i,
  output logic                  disp_a_o,
  output logic                  disp_b_o,
  output logic                  coin_rej_o,
  output logic                  refund_valid_o,
  output logic [CW-1:0]         credit_o,
  output logic [CREDIT_MAX-1:0] credit_led_o
);
  vend_act_e     act;
  logic [CW-1:0] add_steps;
  logic          reject;
  logic          refunding;

  vend_arbiter #(
    .CREDIT_MAX(CREDIT_MAX), .CW(CW), .COIN_LO(COIN_LO), .COIN_HI(COIN_HI),
    .PRICE_A(PRICE_A), .PRICE_B(PRICE_B)
  ) u_arb (
    .credit(credit_o), .refunding(refunding),
    .coin_lo(coin_50_i), .coin_hi(coin_100_i),
    .sel_a(sel_a_i), .sel_b(sel_b_i), .ret(ret_i),
    .act(act), .add_steps(add_steps), .reject(reject)
  );

  vend_credit_core #(
    .CREDIT_MAX(CREDIT_MAX), .CW(CW), .PRICE_A(PRICE_A), .PRICE_B(PRICE_B)
  ) u_core (
    .clk(clk), .rst(rst), .act(act), .add_steps(add_steps), .reject(reject),
    .refund_ready(refund_ready_i), .credit(credit_o), .refunding(refunding),
    .disp_a(disp_a_o), .disp_b(disp_b_o), .coin_rej(coin_rej_o)
  );

  vend_led #(.CREDIT_MAX(CREDIT_MAX), .CW(CW)) u_led (
    .credit(credit_o), .led(credit_led_o)
  );

  assign refund_valid_o = refunding;

endmodule

// File: tb/vend_ctrl_test.sv
module vend_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c50 = 0, c100 = 0, sa = 0, sb = 0, rt = 0, rdy = 1;
  logic disp_a, disp_b, rej, rvalid;
  logic [2:0] credit;
  logic [5:0] led;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  vend_ctrl uut (
    .clk(clk), .rst(rst), .coin_50_i(c50), .coin_100_i(c100),
    .sel_a_i(sa), .sel_b_i(sb), .ret_i(rt), .refund_ready_i(rdy),
    .disp_a_o(disp_a), .disp_b_o(disp_b), .coin_rej_o(rej),
    .refund_valid_o(rvalid), .credit_o(credit), .credit_led_o(led)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // apply pulses on a falling edge; outputs sampled one falling edge later
  task automatic pulse(logic p50, logic p100, logic psa, logic psb, logic prt);
    c50 = p50; c100 = p100; sa = psa; sb = psb; rt = prt;
    @(negedge clk);
    c50 = 0; c100 = 0; sa = 0; sb = 0; rt = 0;
  endtask

  task automatic drain(string tag, int exp_tokens);
    int n = 0;
    rdy = 1;
    while (rvalid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " token count"}, n, exp_tokens);
    chk({tag, " credit zero"}, credit, 0);
  endtask

  function automatic int bar(int c);
    return (1 << c) - 1;
  endfunction

  task automatic t_reset();
    chk("R1 credit", credit, 0);
    chk("R1 led", led, 0);
    chk("R1 strobes", {disp_a, disp_b, rej, rvalid}, 0);
  endtask

  task automatic t_coins();
    pulse(1, 0, 0, 0, 0);
    chk("R2 coin50 credit", credit, 1);
    chk("R2 coin50 led", led, bar(1));
    pulse(0, 1, 0, 0, 0);
    chk("R2 coin100 credit", credit, 3);
    chk("R2 coin100 led", led, bar(3));
    pulse(1, 1, 0, 0, 0);
    chk("R2 pair credit", credit, 6);
    chk("R2 full led", led, bar(6));
  endtask

  task automatic t_ceiling();
    pulse(1, 0, 0, 0, 0);
    chk("R3 reject at 6", rej, 1);
    chk("R3 credit held", credit, 6);
    @(negedge clk);
    chk("R3 reject one clock", rej, 0);
  endtask

  task automatic t_buy_b();
    pulse(0, 0, 0, 1, 0);
    chk("R5 disp_b", disp_b, 1);
    chk("R5 remainder", credit, 2);
    @(negedge clk);
    chk("R5 strobe one clock", disp_b, 0);
  endtask

  task automatic t_buy_a();
    pulse(0, 0, 1, 0, 0);
    chk("R4 disp_a", disp_a, 1);
    chk("R4 credit", credit, 0);
    @(negedge clk);
    chk("R4 strobe one clock", disp_a, 0);
  endtask

  task automatic t_insufficient();
    pulse(0, 0, 1, 0, 0);
    chk("R6 sel_a at 0", disp_a, 0);
    chk("R6 credit 0", credit, 0);
    pulse(0, 1, 0, 0, 0);
    pulse(0, 0, 0, 1, 0);
    chk("R6 sel_b at 2", disp_b, 0);
    chk("R6 credit kept", credit, 2);
  endtask

  task automatic t_both_sel();
    pulse(0, 0, 1, 1, 0);
    chk("R7 disp_a", disp_a, 1);
    chk("R7 disp_b ignored", disp_b, 0);
    chk("R7 credit", credit, 0);
  endtask

  task automatic t_sel_coin();
    pulse(0, 1, 0, 0, 0);
    pulse(1, 0, 1, 0, 0);
    chk("R8 disp_a", disp_a, 1);
    chk("R8 coin rejected", rej, 1);
    chk("R8 credit", credit, 0);
  endtask

  task automatic t_ceiling_mid();
    for (int i = 0; i < 5; i++) pulse(1, 0, 0, 0, 0);
    pulse(0, 1, 0, 0, 0);
    chk("R3 coin100 at 5 rejected", rej, 1);
    chk("R3 credit 5", credit, 5);
  endtask

  task automatic t_refund();
    rdy = 1;
    pulse(0, 0, 0, 0, 1);
    chk("R9 valid raised", rvalid, 1);
    chk("R9 credit at start", credit, 5);
    drain("R9", 5);
    chk("R9 valid low", rvalid, 0);
  endtask

  task automatic t_backpressure();
    pulse(0, 1, 0, 0, 0);
    rdy = 0;
    pulse(0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R10 valid held", rvalid, 1);
    chk("R10 credit held", credit, 2);
    drain("R10", 2);
  endtask

  task automatic t_refund_ignore();
    pulse(1, 1, 0, 0, 0);
    rdy = 0;
    pulse(0, 0, 0, 0, 1);
    pulse(0, 1, 0, 0, 0);
    chk("R11 coin no reject", rej, 0);
    pulse(0, 0, 1, 0, 0);
    chk("R11 no dispense", disp_a, 0);
    pulse(0, 0, 0, 0, 1);
    chk("R11 credit unchanged", credit, 3);
    drain("R11", 3);
  endtask

  task automatic t_ret_priority();
    pulse(0, 1, 0, 0, 0);
    pulse(0, 1, 0, 0, 0);
    rdy = 0;
    pulse(1, 0, 0, 1, 1);
    chk("R12 refund wins", rvalid, 1);
    chk("R12 no disp_b", disp_b, 0);
    chk("R12 coin rejected", rej, 1);
    chk("R12 credit kept", credit, 4);
    drain("R12", 4);
    pulse(0, 0, 0, 0, 1);
    chk("R12 return at zero", rvalid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_coins();
    t_ceiling();
    t_buy_b();
    t_buy_a();
    t_insufficient();
    t_both_sel();
    t_sel_coin();
    t_ceiling_mid();
    t_refund();
    t_backpressure();
    t_refund_ignore();
    t_ret_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule